// File: doc/BRIEF.md
# Shadow RAM Configuration Controller

This block holds the configuration state of a legacy PC memory chipset and decides, for every access to the upper memory area, where that access lands. Software reaches a 256-byte register file through two I/O ports. It first writes a register number to the index port. It then reads or writes that register through the data port. Three of the registers set up shadow RAM for the C, D, E and F segments (C0000h–FFFFFh). One register also carries the memory wait-state setting. When software writes that register, the block pulses a strobe so that the wait-state logic can pick up the new value.

On the memory side the block is purely combinational. It takes an address and a read/write flag. It raises exactly one of three flags:

- internal shadow DRAM
- external bus
- blocked write

The C, D and E segments each have a global enable bit and four 16 KB window enables. One shared bit decides whether writes to enabled windows go to internal DRAM. The F segment has its own two-state mode with the opposite sense.

The I/O interface is a plain synchronous register port with a chip-select. No valid/ready handshake is used, because every access completes in one cycle and the block never stalls a request.

Top module: `shadow_cfg_ctrl`

## Requirements
- R1: Writing with `io_addr` = 22h loads the index register. A read at 22h returns FFh, so the index is write-only.
- R2: A write at `io_addr` = 24h stores `io_wdata` into the register selected by the index. A read at 24h returns that register. A read at any other address, or with `io_cs` low, returns FFh.
- R3: After a synchronous reset, register 10h reads 3Fh, register 11h reads F0h and every other register reads 00h.
- R4: A data-port write while the index is 10h makes `ws_update` high for exactly the one cycle after the write edge. Data-port writes to any other register leave it low.
- R5: When register 11h bit 7 is 0, reads of F0000h–FFFFFh route internal and writes there are blocked.
- R6: When register 11h bit 7 is 1, reads of F0000h–FFFFFh route external and writes there route internal.
- R7: Register 11h bits 4, 5 and 6 are the global enables of the C, D and E segments. While a segment's bit is 0, reads and writes anywhere in that segment route external, whatever its window bits say.
- R8: The 16 KB window enables are mapped as follows:
  - Register 13h bits 4..7 enable C0000h, C4000h, C8000h and CC000h.
  - Register 12h bits 0..3 enable D0000h..DC000h in that order.
  - Register 12h bits 4..7 enable E0000h..EC000h in that order.
  
  A window whose bit is 0 routes reads and writes external.
- R9: In an enabled C/D/E window, reads route internal. Writes route internal when register 11h bit 3 is 1 and external when it is 0.
- R10: Addresses below C0000h always route external, for reads and writes alike.
- R11: Exactly one of `mem_to_internal`, `mem_to_external` and `mem_blocked` is high at all times. `mem_blocked` only ever rises for writes to the F segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous reset |
| io_cs | input | 1 | I/O chip-select |
| io_wr | input | 1 | 1 = write access, 0 = read access |
| io_addr | input | 8 | I/O port address (22h index, 24h data) |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, combinational |
| ws_update | output | 1 | One-cycle pulse after a write to register 10h |
| mem_addr | input | 20 | Memory access address |
| mem_wr | input | 1 | 1 = memory write, 0 = memory read |
| mem_to_internal | output | 1 | Access goes to internal shadow DRAM |
| mem_to_external | output | 1 | Access goes to the external bus |
| mem_blocked | output | 1 | Write is discarded |

## Verification
The bench walks every one of the twelve C/D/E windows and the F segment, for both reads and writes, under several register patterns. A design that swapped the nibbles of register 12h, or indexed the C windows from bit 0 of register 13h, would shadow the wrong 16 KB range. A segment whose global enable was ignored would route to internal memory although its segment bit is clear. Reversing the F-segment polarity would block writes right after reset, when they should go internal. The bench also checks that the wait-state strobe fires only for register 10h and drops after one cycle, and that reading the index port returns FFh rather than the index value.

// File: rtl/shadow_cfg_pkg.sv
package shadow_cfg_pkg;
  localparam int unsigned IO_AW  = 8;
  localparam int unsigned REG_DW = 8;
  localparam int unsigned MEM_AW = 20;
  localparam int unsigned NSEG_CDE = 3;
  localparam int unsigned NWIN     = 4;

  localparam logic [IO_AW-1:0]  PORT_INDEX = 8'h22;
  localparam logic [IO_AW-1:0]  PORT_DATA  = 8'h24;
  localparam logic [REG_DW-1:0] REG_WAIT   = 8'h10;
  localparam logic [REG_DW-1:0] REG_MODE   = 8'h11;
  localparam logic [REG_DW-1:0] REG_WIN_DE = 8'h12;
  localparam logic [REG_DW-1:0] REG_WIN_C  = 8'h13;

  typedef enum logic [1:0] {
    ROUTE_INT = 2'd0,
    ROUTE_EXT = 2'd1,
    ROUTE_BLK = 2'd2
  } route_e;

  function automatic logic [REG_DW-1:0] reset_value(input int unsigned idx);
    case (idx)
      32'h10:  return 8'h3F;
      32'h11:  return 8'hF0;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import shadow_cfg_pkg::*;
#(
  parameter int unsigned AW = IO_AW,
  parameter int unsigned DW = REG_DW,
  parameter logic [AW-1:0] IDX_PORT = PORT_INDEX,
  parameter logic [AW-1:0] DAT_PORT = PORT_DATA
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          io_cs,
  input  logic          io_wr,
  input  logic [AW-1:0] io_addr,
  input  logic [DW-1:0] io_wdata,
  output logic [DW-1:0] io_rdata,
  output logic          ws_update,
  output logic          f_ext_mode,
  output logic [NSEG_CDE-1:0] seg_glob,
  output logic          cde_wr_int,
  output logic [NWIN-1:0] win_c,
  output logic [NWIN-1:0] win_d,
  output logic [NWIN-1:0] win_e
);
  localparam int unsigned NREG = 1 << DW;

  logic [DW-1:0] index_q;
  logic [DW-1:0] regs [NREG];
  logic          idx_we, dat_we;

  assign idx_we = io_cs && io_wr && (io_addr == IDX_PORT);
  assign dat_we = io_cs && io_wr && (io_addr == DAT_PORT);

  always_ff @(posedge clk) begin
    if (rst) index_q <= '0;
    else if (idx_we) index_q <= io_wdata;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) regs[g] <= reset_value(g);
      else if (dat_we && (index_q == DW'(g))) regs[g] <= io_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ws_update <= 1'b0;
    else     ws_update <= dat_we && (index_q == REG_WAIT);
  end

  assign io_rdata = (io_cs && (io_addr == DAT_PORT)) ? regs[index_q] : '1;

  assign f_ext_mode = regs[REG_MODE][7];
  assign seg_glob   = regs[REG_MODE][6:4];
  assign cde_wr_int = regs[REG_MODE][3];
  assign win_c      = regs[REG_WIN_C][7:4];
  assign win_d      = regs[REG_WIN_DE][3:0];
  assign win_e      = regs[REG_WIN_DE][7:4];

  assert_ws_source_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(ws_update) |-> $past(io_cs && io_wr && io_addr == DAT_PORT));

  assert_index_load_R1: assert property (@(posedge clk) disable iff (rst)
    (io_cs && io_wr && io_addr == IDX_PORT) |=> (index_q == $past(io_wdata)));

  assert_data_store_R2: assert property (@(posedge clk) disable iff (rst)
    (io_cs && io_wr && io_addr == DAT_PORT) |=> (regs[$past(index_q)] == $past(io_wdata)));
endmodule

// File: rtl/shadow_decode.sv
module shadow_decode
  import shadow_cfg_pkg::*;
(
  input  logic [5:0]          addr_hi,
  input  logic                wr,
  input  logic                f_ext_mode,
  input  logic [NSEG_CDE-1:0] seg_glob,
  input  logic                cde_wr_int,
  input  logic [NWIN-1:0]     win_c,
  input  logic [NWIN-1:0]     win_d,
  input  logic [NWIN-1:0]     win_e,
  output route_e              route
);
  logic [NWIN-1:0] seg_win [4];
  logic [3:0]      seg_on;
  logic            upper;
  logic [1:0]      seg;
  logic [1:0]      win;
  logic            win_en;

  assign seg_win[0] = win_c;
  assign seg_win[1] = win_d;
  assign seg_win[2] = win_e;
  assign seg_win[3] = '0;

  for (genvar s = 0; s < 4; s++) begin : g_seg
    if (s < NSEG_CDE) begin : g_cde
      assign seg_on[s] = seg_glob[s];
    end else begin : g_f
      assign seg_on[s] = 1'b0;
    end
  end

  assign upper  = (addr_hi[5:4] == 2'b11);
  assign seg    = addr_hi[3:2];
  assign win    = addr_hi[1:0];
  assign win_en = seg_on[seg] & seg_win[seg][win];

  always_comb begin
    if (!upper)            route = ROUTE_EXT;
    else if (seg == 2'd3) begin
      if (!f_ext_mode)     route = wr ? ROUTE_BLK : ROUTE_INT;
      else                 route = wr ? ROUTE_INT : ROUTE_EXT;
    end
    else if (!win_en)      route = ROUTE_EXT;
    else if (!wr)          route = ROUTE_INT;
    else                   route = cde_wr_int ? ROUTE_INT : ROUTE_EXT;
  end
endmodule

// File: rtl/shadow_cfg_ctrl.sv
module shadow_cfg_ctrl
  import shadow_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        io_cs,
  input  logic        io_wr,
  input  logic [7:0]  io_addr,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  output logic        ws_update,
  input  logic [19:0] mem_addr,
  input  logic        mem_wr,
  output logic        mem_to_internal,
  output logic        mem_to_external,
  output logic        mem_blocked
);
  logic                f_ext_mode, cde_wr_int;
  logic [NSEG_CDE-1:0] seg_glob;
  logic [NWIN-1:0]     win_c, win_d, win_e;
  route_e              route;

  cfg_regfile #(
    .AW(IO_AW), .DW(REG_DW), .IDX_PORT(PORT_INDEX), .DAT_PORT(PORT_DATA)
  ) i_regs (
    .clk(clk), .rst(rst), .io_cs(io_cs), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .ws_update(ws_update),
    .f_ext_mode(f_ext_mode), .seg_glob(seg_glob), .cde_wr_int(cde_wr_int),
    .win_c(win_c), .win_d(win_d), .win_e(win_e)
  );

  shadow_decode i_dec (
    .addr_hi(mem_addr[MEM_AW-1:MEM_AW-6]), .wr(mem_wr),
    .f_ext_mode(f_ext_mode), .seg_glob(seg_glob), .cde_wr_int(cde_wr_int),
    .win_c(win_c), .win_d(win_d), .win_e(win_e), .route(route)
  );

  assign mem_to_internal = (route == ROUTE_INT);
  assign mem_to_external = (route == ROUTE_EXT);
  assign mem_blocked     = (route == ROUTE_BLK);

  assert_route_onehot_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot({mem_to_internal, mem_to_external, mem_blocked}));

  assert_block_scope_R11: assert property (@(posedge clk) disable iff (rst)
    mem_blocked |-> (mem_wr && mem_addr[19:16] == 4'hF));

  assert_low_external_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_addr < 20'hC0000) |-> mem_to_external);

  assert_f_read_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_addr[19:16] == 4'hF && !mem_wr && !f_ext_mode) |-> mem_to_internal);
endmodule

// File: tb/test_shadow_cfg_ctrl.sv
module test_shadow_cfg_ctrl;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        io_cs = 1'b0, io_wr = 1'b0;
  logic [7:0]  io_addr = '0, io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        ws_update;
  logic [19:0] mem_addr = '0;
  logic        mem_wr = 1'b0;
  logic        mem_to_internal, mem_to_external, mem_blocked;

  int checks = 0;
  int failures = 0;
  logic [7:0] m11 = 8'hF0, m12 = 8'h00, m13 = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  shadow_cfg_ctrl i_shadow_cfg_ctrl (
    .clk(clk), .rst(rst), .io_cs(io_cs), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .ws_update(ws_update),
    .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_to_internal(mem_to_internal),
    .mem_to_external(mem_to_external), .mem_blocked(mem_blocked)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_cs = 1; io_wr = 1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_cs = 0; io_wr = 0;
  endtask

  task automatic io_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    io_cs = 1; io_wr = 0; io_addr = a;
    #1 d = io_rdata;
    io_cs = 0;
  endtask

  task automatic set_reg(input logic [7:0] r, input logic [7:0] d);
    io_write(8'h22, r);
    io_write(8'h24, d);
    if (r == 8'h11) m11 = d;
    if (r == 8'h12) m12 = d;
    if (r == 8'h13) m13 = d;
  endtask

  // 0 internal, 1 external, 2 blocked
  function automatic logic [1:0] exp_route(input logic [19:0] a, input logic w);
    logic [1:0] s, win;
    logic en;
    if (a < 20'hC0000) return 2'd1;
    s = a[17:16]; win = a[15:14];
    if (s == 2'd3) begin
      if (!m11[7]) return w ? 2'd2 : 2'd0;
      return w ? 2'd0 : 2'd1;
    end
    case (s)
      2'd0: en = m11[4] & m13[4 + win];
      2'd1: en = m11[5] & m12[win];
      default: en = m11[6] & m12[4 + win];
    endcase
    if (!en) return 2'd1;
    if (!w) return 2'd0;
    return m11[3] ? 2'd0 : 2'd1;
  endfunction

  task automatic check_mem(input string req, input logic [19:0] a, input logic w);
    logic [1:0] act;
    @(negedge clk);
    mem_addr = a; mem_wr = w;
    #1;
    act = mem_blocked ? 2'd2 : (mem_to_external ? 2'd1 : 2'd0);
    check(req, {29'd0, mem_blocked & (mem_to_internal | mem_to_external), act},
          {30'd0, exp_route(a, w)});
    check("R11", {29'd0, mem_to_internal, mem_to_external, mem_blocked} == 3'b100 ||
                 {mem_to_internal, mem_to_external, mem_blocked} == 3'b010 ||
                 {mem_to_internal, mem_to_external, mem_blocked} == 3'b001, 1);
  endtask

  task automatic sweep(input string req);
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 4; w++)
        for (int wr = 0; wr < 2; wr++)
          check_mem(req, 20'hC0000 + 20'(s * 20'h10000) + 20'(w * 20'h4000) + 20'h0123, wr[0]);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    io_write(8'h22, 8'h10); io_read(8'h24, d); check("R3 reg10", d, 8'h3F);
    io_write(8'h22, 8'h11); io_read(8'h24, d); check("R3 reg11", d, 8'hF0);
    io_write(8'h22, 8'h12); io_read(8'h24, d); check("R3 reg12", d, 8'h00);
    io_write(8'h22, 8'h13); io_read(8'h24, d); check("R3 reg13", d, 8'h00);
    io_write(8'h22, 8'hFF); io_read(8'h24, d); check("R3 regFF", d, 8'h00);
    sweep("R6 R8 reset routing");
  endtask

  task automatic t_ports;
    logic [7:0] d;
    io_write(8'h22, 8'h5A);
    io_read(8'h22, d); check("R1 index read FFh", d, 8'hFF);
    io_write(8'h24, 8'hA5);
    io_read(8'h24, d); check("R2 data readback", d, 8'hA5);
    io_write(8'h22, 8'h5B);
    io_read(8'h24, d); check("R1 R2 other index", d, 8'h00);
    io_write(8'h22, 8'h5A);
    io_read(8'h24, d); check("R2 index return", d, 8'hA5);
    io_read(8'h30, d); check("R2 undecoded FFh", d, 8'hFF);
    @(negedge clk); io_cs = 0; io_addr = 8'h24; #1;
    check("R2 no cs FFh", io_rdata, 8'hFF);
  endtask

  task automatic t_ws;
    io_write(8'h22, 8'h10);
    @(negedge clk); io_cs = 1; io_wr = 1; io_addr = 8'h24; io_wdata = 8'h21;
    @(negedge clk); io_cs = 0; io_wr = 0;
    check("R4 pulse high", ws_update, 1);
    @(negedge clk);
    check("R4 pulse one cycle", ws_update, 0);
    io_write(8'h22, 8'h14);
    @(negedge clk); io_cs = 1; io_wr = 1; io_addr = 8'h24; io_wdata = 8'h77;
    @(negedge clk); io_cs = 0; io_wr = 0;
    check("R4 no pulse other reg", ws_update, 0);
  endtask

  task automatic t_f_region;
    set_reg(8'h11, 8'h70);
    check_mem("R5 F read internal", 20'hF8000, 0);
    check_mem("R5 F write blocked", 20'hFFFFF, 1);
    set_reg(8'h11, 8'hF0);
    check_mem("R6 F read external", 20'hF0000, 0);
    check_mem("R6 F write internal", 20'hF4000, 1);
  endtask

  task automatic t_windows;
    set_reg(8'h11, 8'hF8);
    set_reg(8'h12, 8'h5A);
    set_reg(8'h13, 8'hA0);
    sweep("R8 R9 mixed windows wr-int");
    set_reg(8'h11, 8'h70);
    set_reg(8'h12, 8'hC3);
    set_reg(8'h13, 8'h50);
    sweep("R8 R9 mixed windows wr-ext");
    set_reg(8'h12, 8'hFF);
    set_reg(8'h13, 8'hF0);
    sweep("R9 all windows");
  endtask

  task automatic t_global;
    set_reg(8'h12, 8'hFF);
    set_reg(8'h13, 8'hF0);
    set_reg(8'h11, 8'h88);
    sweep("R7 all globals off");
    set_reg(8'h11, 8'h28);
    sweep("R7 only D on");
    set_reg(8'h11, 8'h58);
    sweep("R7 C and E on");
  endtask

  task automatic t_low;
    set_reg(8'h11, 8'h78);
    check_mem("R10 zero", 20'h00000, 0);
    check_mem("R10 below C", 20'hBFFFF, 1);
    check_mem("R10 A000 rd", 20'hA0000, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_ports();
    t_ws();
    t_f_region();
    t_windows();
    t_global();
    t_low();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule